// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 16-bit successive-approximation converter. A convert-start pulse begins a conversion. The block then drives a trial word to an external feedback DAC. At each step it takes one keep-or-reject decision from an analog comparator, working strictly from the most significant bit down. It also produces a busy flag, a gated conversion clock, a parallel result word and an NRZ serial stream, all in complementary (negative-true) form.

The step rate comes from a clock-enable input in internal mode. In external mode, the trailing rising edge of each narrow low pulse on the convert-start pin supplies one step. A 3-bit resolution code selects how many bits are resolved (8, 10, 12, 13, 14, 15 or 16). When that many bits are decided, the conversion stops early. The final word then stays on the outputs until the next conversion begins.

Top module: `sar_seq_core`

## Requirements
- R1: While reset is high and after it is released, busy and gclk are 0, dac_trial and par_out are all ones, and ser_out is 1.
- R2: In internal mode, the falling edge of conv_start seen while idle raises busy and loads dac_trial and par_out with all ones. A convert start needs two clocks to pass the synchronizer and one clock for the edge detector.
- R3: The first step after a start puts only the MSB (bit 15) into its trial state. The trial state is a 0, so dac_trial becomes 16'h7FFF.
- R4: Step k (k >= 1) decides bit 16-k. When cmp_in is 1 the bit is kept and driven as 0; when cmp_in is 0 it is rejected and driven as 1. The same step puts the next lower bit into trial. par_out changes by at most one bit per clock while busy.
- R5: gclk is high for exactly one clock per step, so a conversion of N bits produces N+1 high cycles. gclk is 0 whenever busy is 0.
- R6: res_sel codes 0,1,2,3,4,5,6 select N = 16,15,14,13,12,10,8, and code 7 selects 16. Bits below the N resolved ones stay 1 in both dac_trial and par_out.
- R7: busy falls one clock after the step that decides the last bit. At that point par_out equals dac_trial and is unchanged.
- R8: At each deciding step, ser_out takes the complemented decision of that bit (MSB first). At a start, ser_out is set to 1.
- R9: With ext_mode high (idle level of conv_start high), the rising edge ending each low pulse is one step. The first pulse starts the conversion and performs step 0 at once (dac_trial = 16'h7FFF, gclk high). busy falls after pulse N+1.
- R10: In internal mode, a convert start while busy is ignored, and the running conversion completes with its original result and step count.
- R11: While idle, clk_en pulses have no effect: par_out, dac_trial and gclk stay unchanged.
- R12: res_sel is captured at the start. Changing it during a conversion does not alter the number of bits resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Convert start (asynchronous, synchronized inside) |
| ext_mode | input | 1 | 1: start pin pulses clock the steps |
| clk_en | input | 1 | Step strobe in internal mode |
| res_sel | input | 3 | Resolution code |
| cmp_in | input | 1 | Comparator: 1 means input at or above DAC trial level |
| busy | output | 1 | Conversion in progress |
| gclk | output | 1 | Gated conversion clock, one high cycle per step |
| dac_trial | output | 16 | Complementary trial word to the feedback DAC |
| par_out | output | 16 | Complementary parallel result |
| ser_out | output | 1 | Complementary NRZ serial result, MSB first |

## Verification
The assertions rely on several conditions. In internal mode, clk_en pulses are separated by at least one idle clock. ext_mode changes only while reset is held, and conv_start sits at that mode's idle level during reset. Every level of conv_start lasts at least two clocks, so the synchronizer cannot miss an edge. The stimulus drives clk_en with a spacing of two or three clocks. It holds conv_start in each phase for two or more clocks, and it switches mode only inside a fresh reset with conv_start at the new idle level.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;

  // Number of bits resolved for a resolution code, for a word of w bits.
  function automatic int unsigned res_bits(input logic [2:0] code, input int unsigned w);
    int unsigned drop;
    case (code)
      3'd0:    drop = 0;
      3'd1:    drop = 1;
      3'd2:    drop = 2;
      3'd3:    drop = 3;
      3'd4:    drop = 4;
      3'd5:    drop = 6;
      3'd6:    drop = 8;
      default: drop = 0;
    endcase
    if (drop >= w) return 1;
    return w - drop;
  endfunction

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_start,
  input  logic ext_mode,
  input  logic clk_en,
  output logic start_evt,
  output logic tick
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= ext_mode;
          else     chain_q[g] <= conv_start;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= ext_mode;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  logic lvl_now, lvl_old, rise, fall;
  assign lvl_now = chain_q[CHAIN-2];
  assign lvl_old = chain_q[CHAIN-1];
  assign rise    = lvl_now & ~lvl_old;
  assign fall    = ~lvl_now & lvl_old;

  // Trailing edge: end of a positive pulse (internal) or of a negative pulse (external).
  assign start_evt = ext_mode ? rise : fall;
  assign tick      = ext_mode ? rise : clk_en;
endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_evt,
  input  logic             tick,
  input  logic             ext_mode,
  input  logic [2:0]       res_sel,
  output logic             busy,
  output logic             gclk,
  output logic             load_all,
  output logic [WIDTH-1:0] trial_hot,
  output logic [WIDTH-1:0] decide_hot
);
  localparam int STEP_W = $clog2(WIDTH + 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [STEP_W-1:0] nbits_q, nbits_d;
  logic              gclk_d;
  logic              do_step;
  logic              is_last;

  assign is_last = (step_q == nbits_q);

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    nbits_d    = nbits_q;
    gclk_d     = 1'b0;
    load_all   = 1'b0;
    trial_hot  = '0;
    decide_hot = '0;
    do_step    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_evt) begin
          load_all = 1'b1;
          nbits_d  = STEP_W'(res_bits(res_sel, WIDTH));
          state_d  = ST_RUN;
          if (ext_mode) begin
            trial_hot[WIDTH-1] = 1'b1;
            step_d             = STEP_W'(1);
            gclk_d             = 1'b1;
          end else begin
            step_d = '0;
          end
        end
      end
      ST_RUN: begin
        do_step = tick;
        if (do_step) begin
          gclk_d = 1'b1;
          for (int i = 0; i < WIDTH; i++) begin
            if ((step_q != '0) && ((WIDTH - i) == int'(step_q)))
              decide_hot[i] = 1'b1;
            if (!is_last && ((WIDTH - 1 - i) == int'(step_q)))
              trial_hot[i] = 1'b1;
          end
          if (is_last) state_d = ST_DRAIN;
          else         step_d  = step_q + STEP_W'(1);
        end
      end
      ST_DRAIN: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      nbits_q <= STEP_W'(WIDTH);
      gclk    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      nbits_q <= nbits_d;
      gclk    <= gclk_d;
      busy    <= (state_d != ST_IDLE);
    end
  end
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_all,
  input  logic [WIDTH-1:0] trial_hot,
  input  logic [WIDTH-1:0] decide_hot,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] dac_trial,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          dac_trial[g] <= 1'b1;
          par_out[g]   <= 1'b1;
        end else begin
          if (load_all) begin
            dac_trial[g] <= 1'b1;
            par_out[g]   <= 1'b1;
          end
          if (trial_hot[g]) dac_trial[g] <= 1'b0;
          if (decide_hot[g]) begin
            dac_trial[g] <= ~cmp_in;
            par_out[g]   <= ~cmp_in;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)              ser_out <= 1'b1;
    else if (load_all)    ser_out <= 1'b1;
    else if (|decide_hot) ser_out <= ~cmp_in;
  end
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic             ext_mode,
  input  logic             clk_en,
  input  logic [2:0]       res_sel,
  input  logic             cmp_in,
  output logic             busy,
  output logic             gclk,
  output logic [WIDTH-1:0] dac_trial,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out
);
  logic             start_evt, tick, load_all;
  logic [WIDTH-1:0] trial_hot, decide_hot;

  sar_start_detect #(.SYNC_STAGES(SYNC_STAGES)) i_detect (
    .clk       (clk),
    .rst       (rst),
    .conv_start(conv_start),
    .ext_mode  (ext_mode),
    .clk_en    (clk_en),
    .start_evt (start_evt),
    .tick      (tick)
  );

  sar_step_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_evt (start_evt),
    .tick      (tick),
    .ext_mode  (ext_mode),
    .res_sel   (res_sel),
    .busy      (busy),
    .gclk      (gclk),
    .load_all  (load_all),
    .trial_hot (trial_hot),
    .decide_hot(decide_hot)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .load_all  (load_all),
    .trial_hot (trial_hot),
    .decide_hot(decide_hot),
    .cmp_in    (cmp_in),
    .dac_trial (dac_trial),
    .par_out   (par_out),
    .ser_out   (ser_out)
  );
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_mode,
  input logic             busy,
  input logic             gclk,
  input logic [WIDTH-1:0] dac_trial,
  input logic [WIDTH-1:0] par_out
);
  localparam logic [WIDTH-1:0] ALL1  = '1;
  localparam logic [WIDTH-1:0] MSB_T = {1'b0, {(WIDTH-1){1'b1}}};

  p_gclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !gclk);

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !ext_mode) |-> (dac_trial == ALL1 && par_out == ALL1));

  p_ext_start_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && ext_mode) |-> (dac_trial == MSB_T && gclk));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(par_out) && $stable(dac_trial)));

  p_one_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($countones(par_out ^ $past(par_out)) <= 1));

  p_last_stable_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($stable(par_out) && par_out == dac_trial));
endmodule

bind sar_seq_core sar_seq_checker #(.WIDTH(WIDTH)) i_sar_chk (
  .clk      (clk),
  .rst      (rst),
  .ext_mode (ext_mode),
  .busy     (busy),
  .gclk     (gclk),
  .dac_trial(dac_trial),
  .par_out  (par_out)
);

// File: tb/test_sar_seq_core.sv
module test_sar_seq_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst = 1'b1, conv_start = 1'b0, ext_mode = 1'b0, clk_en = 1'b0;
  logic [2:0] res_sel = 3'd0;
  logic cmp_in, busy, gclk, ser_out;
  logic [W-1:0] dac_trial, par_out;
  logic [W-1:0] analog = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [W-1:0] word; int n; } res_t;
  logic ser_q[$];
  res_t res_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural comparator: keep the bit when the input is at or above the DAC level.
  assign cmp_in = (analog >= ~dac_trial);

  sar_seq_core i_sar_seq_core (
    .clk(clk), .rst(rst), .conv_start(conv_start), .ext_mode(ext_mode),
    .clk_en(clk_en), .res_sel(res_sel), .cmp_in(cmp_in), .busy(busy),
    .gclk(gclk), .dac_trial(dac_trial), .par_out(par_out), .ser_out(ser_out)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [2:0] c);
    case (c)
      3'd1: return 15; 3'd2: return 14; 3'd3: return 13; 3'd4: return 12;
      3'd5: return 10; 3'd6: return 8; default: return 16;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_word(input logic [W-1:0] a, input int n);
    logic [W-1:0] m;
    m = ~({W{1'b1}} >> n);
    return ~(a & m);
  endfunction

  task automatic push_expect(input logic [W-1:0] a, input int n);
    res_t r;
    for (int k = 1; k <= n; k++) ser_q.push_back(~a[W-k]);
    r.word = exp_word(a, n);
    r.n = n;
    res_q.push_back(r);
  endtask

  // Monitor / scoreboard
  logic prev_busy = 1'b0;
  int pulse_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!prev_busy && busy) begin
        pulse_cnt = 0;
        if (ext_mode) check(dac_trial == 16'h7FFF, "R9 ext start trial", dac_trial, 16'h7FFF);
        else          check(dac_trial == 16'hFFFF, "R2 start load", dac_trial, 16'hFFFF);
      end
      if (gclk) begin
        pulse_cnt++;
        if (pulse_cnt == 1 && !ext_mode)
          check(dac_trial == 16'h7FFF, "R3 first step", dac_trial, 16'h7FFF);
        if (pulse_cnt >= 2) begin
          if (ser_q.size() == 0) check(1'b0, "R8 serial unexpected", {15'd0, ser_out}, 16'd0);
          else begin
            logic e;
            e = ser_q.pop_front();
            check(ser_out == e, "R8 serial bit", {15'd0, ser_out}, {15'd0, e});
          end
        end
      end
      if (prev_busy && !busy) begin
        if (res_q.size() == 0) check(1'b0, "R7 unexpected end", par_out, 16'd0);
        else begin
          res_t r;
          r = res_q.pop_front();
          check(par_out == r.word, "R4 R6 result", par_out, r.word);
          check(dac_trial == r.word, "R7 trial equals result", dac_trial, r.word);
          check(pulse_cnt == r.n + 1, "R5 gclk count", W'(pulse_cnt), W'(r.n + 1));
        end
      end
      prev_busy = busy;
    end else prev_busy = 1'b0;
  end

  task automatic do_reset(input logic ext);
    @(negedge clk);
    rst = 1'b1; ext_mode = ext; conv_start = ext; clk_en = 1'b0;
    ser_q.delete(); res_q.delete();
    repeat (4) @(negedge clk);
    check(busy == 0 && gclk == 0, "R1 reset busy/gclk", {14'd0, busy, gclk}, 16'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(dac_trial == '1 && par_out == '1, "R1 reset words", dac_trial & par_out, 16'hFFFF);
    check(ser_out == 1 && busy == 0, "R1 reset ser/busy", {14'd0, ser_out, busy}, 16'd2);
  endtask

  task automatic run_int(input logic [W-1:0] a, input logic [2:0] code, input int spacing,
                         input bit restart, input bit change_sel);
    bit seen = 0;
    analog = a; res_sel = code;
    push_expect(a, nbits_of(code));
    @(negedge clk); conv_start = 1'b1;
    repeat (3) @(negedge clk); conv_start = 1'b0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      clk_en = (cyc % spacing == 0);
      if (restart && cyc == 12) conv_start = 1'b1;
      if (restart && cyc == 16) conv_start = 1'b0;
      if (change_sel && cyc == 8) res_sel = code ^ 3'd6;
      if (busy) seen = 1;
      if (seen && !busy) break;
    end
    clk_en = 1'b0;
    check(seen, "R2 conversion ran", {15'd0, seen}, 16'd1);
    @(negedge clk);
  endtask

  task automatic run_ext(input logic [W-1:0] a, input logic [2:0] code);
    int pulses = 0;
    analog = a; res_sel = code;
    push_expect(a, nbits_of(code));
    for (int p = 0; p < 24; p++) begin
      @(negedge clk); conv_start = 1'b0;
      repeat (2) @(negedge clk); conv_start = 1'b1;
      pulses++;
      repeat (7) @(negedge clk);
      if (!busy) break;
    end
    check(pulses == nbits_of(code) + 1, "R9 pulse count", W'(pulses), W'(nbits_of(code) + 1));
  endtask

  initial begin
    logic [W-1:0] held;
    do_reset(1'b0);
    // R11: clk_en while idle does nothing
    for (int i = 0; i < 10; i++) begin @(negedge clk); clk_en = ~clk_en; end
    clk_en = 1'b0; @(negedge clk);
    check(par_out == '1 && dac_trial == '1 && gclk == 0, "R11 idle ticks", par_out & dac_trial, 16'hFFFF);

    run_int(16'hA5C3, 3'd0, 2, 0, 0);
    run_int(16'h0000, 3'd0, 3, 0, 0);
    run_int(16'hFFFF, 3'd0, 2, 0, 0);
    run_int(16'h8000, 3'd0, 2, 0, 0);
    run_int(16'h7FFF, 3'd0, 3, 0, 0);
    for (int c = 1; c < 8; c++) run_int(16'hB6DB, 3'(c), 2, 0, 0);   // R6 all codes

    held = par_out;
    for (int i = 0; i < 12; i++) begin @(negedge clk); clk_en = (i % 2 == 0); end
    clk_en = 1'b0; @(negedge clk);
    check(par_out == held && dac_trial == held && gclk == 0, "R11 result held", par_out, held);

    run_int(16'h1234, 3'd0, 3, 1, 0);   // R10 restart ignored
    run_int(16'hCAFE, 3'd2, 2, 0, 1);   // R12 res_sel captured
    run_int(16'h4321, 3'd5, 3, 1, 1);   // R10 and R12 together

    do_reset(1'b1);
    run_ext(16'h9C3A, 3'd0);
    run_ext(16'h0F0F, 3'd6);
    run_ext(16'hFFFF, 3'd4);

    repeat (4) @(negedge clk);
    check(ser_q.size() == 0 && res_q.size() == 0, "R8 scoreboard drained",
          W'(ser_q.size() + res_q.size()), 16'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R5 watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule